// File: doc/BRIEF.md
# PTP System Time Counter with Programmable Increment

This block keeps a 64-bit time-of-day counter for a precision time protocol datapath. Every `period` clock cycles the counter adds an increment `value`. Both fields come from one packed rate register, so the resolution and the counting frequency depend only on that register. Timestamp capture logic reads the running time from `time_now`. A one-cycle `step` pulse marks every increment event.

Software uses a small register port that is 32 bits wide. The time is read as two halves: reading the low half freezes the high half in a shadow register, so a later read of the high half belongs to the same instant. Software writes a new time by writing the low half first and then the high half. The new 64-bit value is loaded in a single cycle when the high half is written.

Frequency trim works in one of two ways. Software can rewrite the rate register directly. It can also write a signed parts-per-billion figure to a trim address. The block then scales the nominal increment value by that figure and leaves the period unchanged. The block refuses any trim that is out of range.

A new rate never cuts into a period count that is already running. It is adopted at the next increment event.

Top module: `ptp_systime`

## Requirements
- R1: After a synchronous reset, `time_now` is 0, `rd_valid` and `rdata` are 0, and the rate register holds period `RST_PERIOD` and value `RST_VALUE` (defaults 1 and 8).
- R2: With a nonzero active period P and value V, `step` pulses once every P cycles. `time_now` grows by exactly V on each pulse and holds otherwise, so over any window of k·P cycles it grows by k·V.
- R3: With an active period of 0, `step` never pulses and `time_now` holds its value.
- R4: A rate write is adopted at the next `step` and the count in progress finishes at the old period. If the active period is 0, the write is adopted on the following clock.
- R5: Reads take one cycle: `rd_valid` is high in the cycle after `rd_en`, with `rdata`. Reading address 0 returns time bits 31:0 and latches bits 63:32. A later read of address 1 returns that latched value, even if the time has moved on.
- R6: Writing address 0 only stages a low word and does not change `time_now`. Writing address 1 loads {wdata, staged low word} into the time at that clock edge, in place of any increment due in that cycle.
- R7: The rate register is at address 2, with the period in bits 31:24 and the value in bits 23:0. Reading it returns the most recently accepted setting.
- R8: A write to address 3 carries a signed ppb figure d. It sets the pending value to B + floor(B·|d|/1e9) for d ≥ 0, or to B − floor(B·|d|/1e9) for d < 0. B is the value field of the last rate write, and reading address 3 returns B in bits 23:0. The period field is not changed.
- R9: A trim with d > `MAX_ADJ_PPB` (default 23 999 999) or d ≤ −1 000 000 000 is ignored, and the rate register keeps its previous contents.
- R10: `time_now` always shows the current counter value, and it carries correctly from bit 31 into bit 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 time low, 1 time high, 2 rate, 3 trim |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| time_now | output | 64 | Current system time |
| step | output | 1 | Increment event pulse |

## Verification
A wrong period counter changes the spacing of `step` pulses and the slope of `time_now`, and this shows within one increment period. A rate adopted at the wrong moment shifts the first pulse after the write by a few cycles. A shadow register that latches on the wrong access gives a high word that disagrees with the low word read just before it, which shows up as soon as the low word wraps. A wrong product or bound in the trim datapath shows in the rate readback on the read right after the trim write.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;

    parameter int unsigned PER_W  = 8;
    parameter int unsigned VAL_W  = 24;
    parameter int unsigned REG_W  = PER_W + VAL_W;
    parameter int unsigned TIME_W = 2 * REG_W;
    parameter int unsigned ADDR_W = 2;
    localparam int unsigned PROD_W = VAL_W + REG_W;
    localparam logic [PROD_W-1:0] PPB_SCALE = PROD_W'(1_000_000_000);
    localparam int PPB_FLOOR = -1_000_000_000;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [VAL_W-1:0] value;
    } rate_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME_LO = 2'd0,
        A_TIME_HI = 2'd1,
        A_RATE    = 2'd2,
        A_TRIM    = 2'd3
    } reg_addr_e;

    function automatic logic trim_in_range(input int ppb, input int max_adj);
        return (ppb <= max_adj) && (ppb > PPB_FLOOR);
    endfunction

    function automatic logic [VAL_W-1:0] trim_apply(input logic [VAL_W-1:0] base,
                                                    input int ppb);
        logic [REG_W-1:0]  mag;
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] adj;
        mag  = (ppb < 0) ? REG_W'(-ppb) : REG_W'(ppb);
        prod = PROD_W'(base) * PROD_W'(mag);
        adj  = prod / PPB_SCALE;
        return (ppb < 0) ? (base - adj[VAL_W-1:0]) : (base + adj[VAL_W-1:0]);
    endfunction

endpackage

// File: rtl/ptp_rate_ctl.sv
module ptp_rate_ctl
    import ptp_systime_pkg::*;
#(
    parameter logic [PER_W-1:0] RST_PERIOD  = 8'd1,
    parameter logic [VAL_W-1:0] RST_VALUE   = 24'd8,
    parameter int               MAX_ADJ_PPB = 23_999_999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_wr,
    input  logic             trim_wr,
    input  logic [REG_W-1:0] wdata,
    output rate_cfg_t        pend_cfg,
    output logic [VAL_W-1:0] base_value
);

    logic trim_ok;
    assign trim_ok = trim_in_range(int'(wdata), MAX_ADJ_PPB);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg   <= '{period: RST_PERIOD, value: RST_VALUE};
            base_value <= RST_VALUE;
        end else if (rate_wr) begin
            pend_cfg   <= rate_cfg_t'(wdata);
            base_value <= wdata[VAL_W-1:0];
        end else if (trim_wr && trim_ok) begin
            pend_cfg.value <= trim_apply(base_value, int'(wdata));
        end
    end

endmodule

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen
    import ptp_systime_pkg::*;
#(
    parameter logic [PER_W-1:0] RST_PERIOD = 8'd1,
    parameter logic [VAL_W-1:0] RST_VALUE  = 24'd8
) (
    input  logic      clk,
    input  logic      rst,
    input  rate_cfg_t pend_cfg,
    output rate_cfg_t cur_cfg,
    output logic      step
);

    logic [PER_W-1:0] cnt;
    logic             stopped;
    logic             adopt;

    assign stopped = (cur_cfg.period == '0);
    assign step    = !stopped && (cnt == cur_cfg.period - PER_W'(1));
    assign adopt   = step || stopped;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cfg <= '{period: RST_PERIOD, value: RST_VALUE};
            cnt     <= '0;
        end else if (adopt) begin
            cur_cfg <= pend_cfg;
            cnt     <= '0;
        end else begin
            cnt     <= cnt + PER_W'(1);
        end
    end

endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc
    import ptp_systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [VAL_W-1:0]  inc_value,
    input  logic              load,
    input  logic [TIME_W-1:0] load_time,
    output logic [TIME_W-1:0] time_q
);

    always_ff @(posedge clk) begin
        if (rst)       time_q <= '0;
        else if (load) time_q <= load_time;
        else if (step) time_q <= time_q + TIME_W'(inc_value);
    end

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_systime_pkg::*;
#(
    parameter logic [PER_W-1:0] RST_PERIOD  = 8'd1,
    parameter logic [VAL_W-1:0] RST_VALUE   = 24'd8,
    parameter int               MAX_ADJ_PPB = 23_999_999
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              rd_valid,
    output logic [TIME_W-1:0] time_now,
    output logic              step
);

    reg_addr_e        sel;
    rate_cfg_t        pend_cfg;
    rate_cfg_t        cur_cfg;
    logic [VAL_W-1:0] base_value;
    logic [REG_W-1:0] stage_lo;
    logic [REG_W-1:0] shadow_hi;
    logic             wr_lo, wr_hi, wr_rate, wr_trim, rd_lo;

    assign sel     = reg_addr_e'(addr);
    assign wr_lo   = wr_en && (sel == A_TIME_LO);
    assign wr_hi   = wr_en && (sel == A_TIME_HI);
    assign wr_rate = wr_en && (sel == A_RATE);
    assign wr_trim = wr_en && (sel == A_TRIM);
    assign rd_lo   = rd_en && (sel == A_TIME_LO);

    ptp_rate_ctl #(
        .RST_PERIOD (RST_PERIOD),
        .RST_VALUE  (RST_VALUE),
        .MAX_ADJ_PPB(MAX_ADJ_PPB)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .rate_wr   (wr_rate),
        .trim_wr   (wr_trim),
        .wdata     (wdata),
        .pend_cfg  (pend_cfg),
        .base_value(base_value)
    );

    ptp_tick_gen #(
        .RST_PERIOD(RST_PERIOD),
        .RST_VALUE (RST_VALUE)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .pend_cfg(pend_cfg),
        .cur_cfg (cur_cfg),
        .step    (step)
    );

    ptp_time_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .inc_value(cur_cfg.value),
        .load     (wr_hi),
        .load_time({wdata, stage_lo}),
        .time_q   (time_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo  <= '0;
            shadow_hi <= '0;
            rdata     <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (wr_lo) stage_lo  <= wdata;
            if (rd_lo) shadow_hi <= time_now[TIME_W-1:REG_W];
            if (rd_en) begin
                unique case (sel)
                    A_TIME_LO: rdata <= time_now[REG_W-1:0];
                    A_TIME_HI: rdata <= shadow_hi;
                    A_RATE:    rdata <= pend_cfg;
                    A_TRIM:    rdata <= REG_W'(base_value);
                    default:   rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk
    import ptp_systime_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic              rd_valid,
    input logic [TIME_W-1:0] time_now,
    input logic              step,
    input logic [PER_W-1:0]  cur_period,
    input logic [VAL_W-1:0]  cur_value
);

    logic hi_load;
    assign hi_load = wr_en && (addr == ADDR_W'(1));

    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
        step && !hi_load |=> time_now == $past(time_now) + TIME_W'($past(cur_value))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step && !hi_load |=> $stable(time_now)); // R2
    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
        cur_period == '0 |-> !step); // R3
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        (cur_period != '0) && !step |=> $stable(cur_period) && $stable(cur_value)); // R4
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R5
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R5
    AST_HIGH_LOADS: assert property (@(posedge clk) disable iff (rst)
        hi_load |=> time_now[TIME_W-1:REG_W] == $past(wdata)); // R6

endmodule

bind ptp_systime ptp_systime_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_valid  (rd_valid),
    .time_now  (time_now),
    .step      (step),
    .cur_period(cur_cfg.period),
    .cur_value (cur_cfg.value)
);

// File: tb/tb_ptp_systime.sv
`timescale 1ns/1ps
module tb_ptp_systime;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic [63:0] time_now;
    logic        step;

    always #2 clk = ~clk;

    ptp_systime dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .time_now(time_now), .step(step)
    );

    int    total = 0;
    int    bad = 0;
    bit    started = 0;
    bit    done = 0;
    string phase = "R1";

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // reference model, derived from the requirements
    logic [63:0] m_time;
    logic [31:0] m_stage, m_shadow;
    logic [7:0]  m_per, p_per;
    logic [23:0] m_val, p_val, m_base;
    int          m_cnt;
    logic        m_step;

    function automatic logic [23:0] exp_trim(input logic [23:0] b, input int d);
        longint      mag;
        logic [63:0] adj;
        mag = (d < 0) ? -longint'(d) : longint'(d);
        adj = 64'((longint'(b) * mag) / 64'd1_000_000_000);
        return (d < 0) ? (b - adj[23:0]) : (b + adj[23:0]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_time = '0; m_stage = '0; m_shadow = '0;
            m_per = 8'd1; p_per = 8'd1; m_val = 24'd8; p_val = 24'd8; m_base = 24'd8;
            m_cnt = 0; m_step = 1'b1;
        end else begin
            logic tk, adopt;
            tk    = (m_per != 0) && (m_cnt == int'(m_per) - 1);
            adopt = tk || (m_per == 0);
            if (rd_en) begin
                case (addr)
                    2'd0: begin exp_q.push_back(m_time[31:0]); m_shadow = m_time[63:32]; end
                    2'd1: exp_q.push_back(m_shadow);
                    2'd2: exp_q.push_back({p_per, p_val});
                    default: exp_q.push_back({8'd0, m_base});
                endcase
                tag_q.push_back(phase);
            end
            if (wr_en && addr == 2'd1) m_time = {wdata, m_stage};
            else if (tk)               m_time = m_time + 64'(m_val);
            if (wr_en && addr == 2'd0) m_stage = wdata;
            if (adopt) begin m_per = p_per; m_val = p_val; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
            if (wr_en && addr == 2'd2) begin
                p_per = wdata[31:24]; p_val = wdata[23:0]; m_base = wdata[23:0];
            end else if (wr_en && addr == 2'd3 &&
                         int'(wdata) <= 23_999_999 && int'(wdata) > -1_000_000_000) begin
                p_val = exp_trim(m_base, int'(wdata));
            end
            m_step = (m_per != 0) && (m_cnt == int'(m_per) - 1);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard and tracks the running time
    always @(negedge clk) begin
        if (started && !rst) begin
            chk({"R10 time_now during ", phase}, time_now, m_time);
            chk({"R2 step during ", phase}, 64'(step), 64'(m_step));
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk({"R5 unexpected read data in ", phase}, 64'(rdata), 64'hx);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " read data"}, 64'(rdata), 64'(e));
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired in %s", phase);
            summary();
        end
    end

    initial begin
        logic [63:0] t0;
        repeat (3) @(negedge clk);
        chk("R1 time after reset", time_now, 64'd0);
        chk("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        chk("R1 rdata after reset", 64'(rdata), 64'd0);
        rst = 1'b0;
        started = 1'b1;

        phase = "R7"; rd(2'd2); rd(2'd3);

        phase = "R2"; idle(2); t0 = time_now; idle(10);
        chk("R2 ten cycles at period 1", time_now - t0, 64'd80);

        phase = "R6"; wr(2'd0, 32'hFFFF_FFF0);
        wr(2'd1, 32'h0000_0001);
        chk("R6 loaded time", time_now, 64'h1_FFFF_FFF0);

        phase = "R5"; rd(2'd0); idle(3); rd(2'd1); rd(2'd0); rd(2'd1);

        phase = "R4"; wr(2'd2, {8'd5, 24'd3}); idle(3);
        t0 = time_now; idle(20);
        chk("R2 window at period 5", time_now - t0, 64'd12);
        wr(2'd2, {8'd7, 24'd2}); idle(12);
        t0 = time_now; idle(14);
        chk("R4 window at period 7", time_now - t0, 64'd4);

        phase = "R3"; wr(2'd2, {8'd0, 24'd9}); idle(10);
        t0 = time_now; idle(20);
        chk("R3 stopped counter", time_now - t0, 64'd0);

        phase = "R4"; wr(2'd2, {8'd2, 24'd5}); idle(2);
        t0 = time_now; idle(10);
        chk("R4 adopted from stop", time_now - t0, 64'd25);

        phase = "R8"; wr(2'd2, {8'd1, 24'h80_0000});
        wr(2'd3, 32'd20_000_000); rd(2'd2); rd(2'd3);
        wr(2'd3, 32'(-500_000_000)); rd(2'd2);
        wr(2'd3, 32'd23_999_999); rd(2'd2);

        phase = "R9"; wr(2'd3, 32'd24_000_000); rd(2'd2);
        wr(2'd3, 32'(-1_000_000_000)); rd(2'd2);
        phase = "R8"; wr(2'd3, 32'(-999_999_999)); rd(2'd2);

        phase = "R6"; wr(2'd0, 32'h0000_0000); idle(2);
        wr(2'd1, 32'h0000_00AB);
        chk("R6 load replaces increment", time_now, 64'hAB_0000_0000);

        phase = "R10"; idle(6);
        chk("R5 all reads answered", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        summary();
    end

endmodule